// File: doc/BRIEF.md
# Long-Period Wake-Up Down Counter

This block is a wide down counter for waking a low-power system after a long interval. It advances on a single-cycle tick enable that stands in for a slow 32 kHz clock. Software writes a start value, sets the interrupt enable, and starts the count. When the count reaches zero the block raises a sticky expiry flag. The interrupt output follows that flag, gated by the enable.

The counter does not halt at zero. It keeps decrementing and wraps through the all-ones value. Software can therefore read the live count after servicing the event and work out how many ticks the response took. A stop strobe freezes the count where it is and never produces an expiry. The running flag, the expired flag and the count can all be observed whether or not the interrupt is enabled.

Top module: `wake_countdown_timer`

## Requirements
- R1: After reset, count_o is zero, running_o is 0, expired_o is 0 and irq_o is 0.
- R2: A load_i strobe puts load_val_i into count_o on the next cycle and clears expired_o. It leaves running_o unchanged. In the same cycle, a load takes priority over a tick decrement and over an expiry.
- R3: A start_i strobe sets running_o on the next cycle. While running_o is 1, each cycle with tick_i high lowers count_o by one on the next cycle. Cycles without tick_i leave count_o unchanged.
- R4: A stop_i strobe clears running_o on the next cycle. A tick in the stop cycle is not applied. While stopped, count_o holds its value and expired_o never becomes set.
- R5: When start_i and stop_i are high in the same cycle, the counter ends up stopped.
- R6: expired_o becomes 1 on the same edge at which a running tick moves count_o from 1 to 0. A load of zero therefore expires only after one full wrap of the counter.
- R7: After expiry the counter continues to decrement: the tick that follows zero yields all-ones, and counting goes on from there.
- R8: expired_o stays set until a clr_exp_i strobe or a load clears it. If an expiry happens in the same cycle as clr_exp_i, the flag stays set.
- R9: irq_o is 1 exactly when expired_o is 1 and irq_en_i is 1. expired_o and running_o can be read even while irq_en_i is 0.
- R10: The parameter CNT_W sets the counter width. It is intended to be 28 or 41, and the default is 28. All wrap arithmetic is modulo 2^CNT_W.
- R11: A load while running_o is 1 keeps the counter running and rearms expiry, so that a later crossing to zero sets expired_o again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow-clock tick enable, one cycle wide |
| load_i | input | 1 | Load strobe |
| load_val_i | input | CNT_W | Value written on load |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| clr_exp_i | input | 1 | Write-one-to-clear strobe for the expired flag |
| irq_en_i | input | 1 | Interrupt enable |
| count_o | output | CNT_W | Live count |
| running_o | output | 1 | Counter is running |
| expired_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Expiry interrupt / wake event |

## Verification
The bench builds one instance with CNT_W = 4. At that width every load value from 0 to 15 can be swept to its zero crossing and on through the full wrap. This covers the expiry of a zero load and the all-ones step at a cost of a few hundred cycles. A second instance at the default CNT_W = 28 runs in parallel under the same stimulus. It confirms that the wrap lands on the 28-bit all-ones value. A long pseudo-random phase mixes load, start, stop, clear and tick in overlapping cycles, which exercises the priority rules between them.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
    typedef enum logic [1:0] {
        RUN_HOLD = 2'd0,
        RUN_SET  = 2'd1,
        RUN_CLR  = 2'd2
    } run_cmd_e;
endpackage

// File: rtl/wkt_cmd.sv
module wkt_cmd
    import wkt_pkg::*;
(
    input  logic     start_i,
    input  logic     stop_i,
    output run_cmd_e cmd_o
);
    // stop outranks start when both arrive together
    always_comb begin
        if (stop_i)       cmd_o = RUN_CLR;
        else if (start_i) cmd_o = RUN_SET;
        else              cmd_o = RUN_HOLD;
    end
endmodule

// File: rtl/wkt_step.sv
module wkt_step #(
    parameter int unsigned CNT_W = 28
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] nxt_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // modulo decrement; zero wraps to all-ones
    assign nxt_o  = cnt_i - ONE;
    assign last_o = (cnt_i == ONE);
endmodule

// File: rtl/wake_countdown_timer.sv
module wake_countdown_timer
    import wkt_pkg::*;
#(
    parameter int unsigned CNT_W = 28
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             clr_exp_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             expired_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             exp;
    } state_t;

    localparam state_t RST_STATE = '{cnt: '0, run: 1'b0, exp: 1'b0};

    state_t           state_d, state_q;
    run_cmd_e         run_cmd;
    logic [CNT_W-1:0] cnt_dec;
    logic             cnt_last;
    logic             advance;

    wkt_cmd u_cmd (
        .start_i (start_i),
        .stop_i  (stop_i),
        .cmd_o   (run_cmd)
    );

    wkt_step #(.CNT_W(CNT_W)) u_step (
        .cnt_i  (state_q.cnt),
        .nxt_o  (cnt_dec),
        .last_o (cnt_last)
    );

    assign advance = state_q.run & tick_i & ~stop_i;

    always_comb begin
        state_d = state_q;
        unique case (run_cmd)
            RUN_SET: state_d.run = 1'b1;
            RUN_CLR: state_d.run = 1'b0;
            default: state_d.run = state_q.run;
        endcase
        if (clr_exp_i) begin
            state_d.exp = 1'b0;
        end
        if (load_i) begin
            state_d.cnt = load_val_i;
            state_d.exp = 1'b0;
        end else if (advance) begin
            state_d.cnt = cnt_dec;
            if (cnt_last) begin
                state_d.exp = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RST_STATE;
        else         state_q <= state_d;
    end

    assign count_o   = state_q.cnt;
    assign running_o = state_q.run;
    assign expired_o = state_q.exp;
    assign irq_o     = state_q.exp & irq_en_i;
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker #(
    parameter int unsigned CNT_W = 28
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             load_i,
    input logic [CNT_W-1:0] load_val_i,
    input logic             start_i,
    input logic             stop_i,
    input logic             clr_exp_i,
    input logic [CNT_W-1:0] count_o,
    input logic             running_o,
    input logic             expired_o,
    input logic             irq_o
);
    AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (count_o == $past(load_val_i)) && !expired_o); // R2
    AST_TICK_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && tick_i && !load_i && !stop_i) |=> count_o == CNT_W'($past(count_o) - 1'b1)); // R3
    AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_o && !load_i) |=> $stable(count_o)); // R4
    AST_NO_EXP_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_o |=> !$rose(expired_o)); // R4
    AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && stop_i) |=> !running_o); // R5
    AST_EXP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(expired_o) |-> count_o == '0); // R6
    AST_WRAP_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && tick_i && !load_i && !stop_i && count_o == '0) |=> count_o == '1); // R7
    AST_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_exp_i && !running_o) |=> !expired_o); // R8
    AST_IRQ_NEEDS_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> expired_o); // R9
endmodule

bind wake_countdown_timer wkt_checker #(.CNT_W(CNT_W)) u_wkt_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .clr_exp_i  (clr_exp_i),
    .count_o    (count_o),
    .running_o  (running_o),
    .expired_o  (expired_o),
    .irq_o      (irq_o)
);

// File: tb/wake_countdown_timer_bench.sv
module wake_countdown_timer_bench;
    localparam int NW = 4;
    localparam int WW = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, load = 1'b0, start = 1'b0, stop = 1'b0, clr = 1'b0, en = 1'b0;
    logic [NW-1:0] val = '0;
    logic [NW-1:0] cnt_n;
    logic [WW-1:0] cnt_w;
    logic run_n, exp_n, irq_n, run_w, exp_w, irq_w;

    int checks = 0;
    int errors = 0;
    logic [40:0] m_cn, m_cw;
    logic m_run, m_en, m_exn, m_exw;

    always #2.5 clk = ~clk;

    wake_countdown_timer #(.CNT_W(NW)) u_wake_countdown_timer (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .load_i(load), .load_val_i(val),
        .start_i(start), .stop_i(stop), .clr_exp_i(clr), .irq_en_i(en),
        .count_o(cnt_n), .running_o(run_n), .expired_o(exp_n), .irq_o(irq_n));

    wake_countdown_timer #(.CNT_W(WW)) u_wake_countdown_timer_wide (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .load_i(load), .load_val_i({{(WW-NW){1'b0}}, val}),
        .start_i(start), .stop_i(stop), .clr_exp_i(clr), .irq_en_i(en),
        .count_o(cnt_w), .running_o(run_w), .expired_o(exp_w), .irq_o(irq_w));

    task automatic chk(input logic ok, input string tag, input logic [40:0] act, input logic [40:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic upd_cnt(inout logic [40:0] c, inout logic e, input logic [40:0] mask);
        if (clr) e = 1'b0;
        if (load) begin
            c = {{(41-NW){1'b0}}, val};
            e = 1'b0;
        end else if (m_run && tick && !stop) begin
            if (c == 41'd1) e = 1'b1;
            c = (c - 41'd1) & mask;
        end
    endtask

    task automatic compare();
        chk(cnt_n == m_cn[NW-1:0], "R2 R3 R4 R7 count", 41'(cnt_n), m_cn);
        chk(cnt_w == m_cw[WW-1:0], "R10 wide count", 41'(cnt_w), m_cw);
        chk(run_n == m_run && run_w == m_run, "R3 R4 R5 running", 41'(run_n), 41'(m_run));
        chk(exp_n == m_exn, "R6 R8 R11 expired", 41'(exp_n), 41'(m_exn));
        chk(exp_w == m_exw, "R6 R10 wide expired", 41'(exp_w), 41'(m_exw));
        chk(irq_n == (m_exn & m_en), "R9 irq", 41'(irq_n), 41'(m_exn & m_en));
        chk(irq_w == (m_exw & m_en), "R9 wide irq", 41'(irq_w), 41'(m_exw & m_en));
    endtask

    // one cycle: inputs set before the edge, model advanced, outputs sampled after
    task automatic cyc(input logic ld, input logic [NW-1:0] v, input logic st, input logic sp,
                       input logic tk, input logic cl, input logic ie);
        @(negedge clk);
        load = ld; val = v; start = st; stop = sp; tick = tk; clr = cl; en = ie;
        @(posedge clk);
        #1;
        upd_cnt(m_cn, m_exn, (41'd1 << NW) - 41'd1);
        upd_cnt(m_cw, m_exw, (41'd1 << WW) - 41'd1);
        if (sp) m_run = 1'b0;
        else if (st) m_run = 1'b1;
        m_en = ie;
        compare();
        @(negedge clk);
        load = 1'b0; start = 1'b0; stop = 1'b0; tick = 1'b0; clr = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        m_cn = '0; m_cw = '0; m_run = 1'b0; m_en = 1'b0; m_exn = 1'b0; m_exw = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(cnt_n == '0 && cnt_w == '0, "R1 reset count", 41'(cnt_w), 41'd0);
        chk(!run_n && !exp_n && !irq_n, "R1 reset flags", {38'd0, run_n, exp_n, irq_n}, 41'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 R7: sweep every load value, count ticks to expiry and past the wrap
        for (int v = 0; v < 16; v++) begin
            cyc(1'b1, 4'(v), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
            cyc(1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1); // tick in start cycle not applied
            for (int k = 1; k <= 20; k++) begin
                cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
                chk(cnt_n == 4'((v - k) & 15), "R3 R7 sweep count", 41'(cnt_n), 41'((v - k) & 15));
                chk(exp_n == (k >= ((v == 0) ? 16 : v)), "R6 sweep expiry", 41'(exp_n),
                    41'(k >= ((v == 0) ? 16 : v)));
            end
            // R4: stop with a tick in the same cycle, then idle ticks
            cyc(1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
            repeat (3) cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
            chk(cnt_n == 4'((v - 20) & 15), "R4 frozen count", 41'(cnt_n), 41'((v - 20) & 15));
        end

        // R7 R10: wide wrap lands on 28-bit all-ones
        cyc(1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(cnt_w == 28'hFFFFFFF, "R7 R10 wide all-ones", 41'(cnt_w), 41'h0FFFFFFF);
        chk(exp_w && !irq_w, "R9 status visible while masked", 41'(irq_w), 41'd0);

        // R8: clear coinciding with expiry keeps flag set
        cyc(1'b1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk(exp_n, "R8 set beats clear", 41'(exp_n), 41'd1);
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(!exp_n, "R8 clear strobe", 41'(exp_n), 41'd0);

        // R11: reload while running rearms
        cyc(1'b1, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk(run_n && cnt_n == 4'd1, "R11 reload keeps running", 41'(cnt_n), 41'd1);
        cyc(1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk(exp_n && irq_n, "R11 re-expiry", 41'(irq_n), 41'd1);

        // R5: start and stop together
        cyc(1'b0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        chk(!run_n, "R5 stop wins", 41'(run_n), 41'd0);

        // mixed pseudo-random phase (R2 priority of load over tick and expiry)
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[3:0] == 4'd0, lf[15:12], lf[6:5] == 2'd0, lf[9:7] == 3'd0,
                lf[8] | lf[1], lf[12:10] == 3'd0, lf[13]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule